// File: doc/BRIEF.md
# Per-Bit Edge Detector Bank

The block watches a wide input bus and raises a one-cycle event flag on any bit where a chosen kind of transition occurs. Every input bit has its own detector. Each detector has a 2-bit edge mode, which selects rising, falling or both edges, and a 1-bit mask that silences it. A pulse that combines all bits tells the consumer that at least one detector fired in that cycle.

Software configures the detectors indirectly through a small synchronous write port. It first writes the number of a detector into a selector register. Writes to the mode address or the mask address then land on that detector alone. The whole configuration can be read back as packed 32-bit words: one set of words holds the 2-bit modes and another holds the mask bits. A read address is presented on one cycle and its data appears on the next.

Each input is compared with a registered copy of its value from the previous cycle. Events are therefore registered outputs that follow the input change by one clock.

Top module: `pin_edge_monitor`

## Requirements
- R1: A write to address 0x00 stores wr_data[7:0] as the selected detector number. Reading address 0x00 returns that number, zero-extended.
- R2: A write to address 0x01 with the value 0, 1 or 2 sets the mode of the selected detector. The encoding is 0 = rising edge, 1 = falling edge, 2 = both edges.
- R3: A write to address 0x01 with any value above 2 is ignored, and every stored mode stays as it was.
- R4: A write to address 0x02 with the value 0 or 1 sets the mask bit of the selected detector (1 = silenced). A write to 0x02 with any other value is ignored.
- R5: Reading address 0x10+w, for w from 0 to 15, returns control word w. Detector i sits in bits [2*(i%16)+1 : 2*(i%16)] of word i/16.
- R6: Reading address 0x20+w, for w from 0 to 7, returns mask word w. Detector i sits in bit i%32 of word i/32.
- R7: In rising mode, evt_vec[i] is 1 for exactly the one cycle after the clock edge at which sig_in[i] is first sampled as 1, following a sample of 0.
- R8: In falling mode, evt_vec[i] is 1 for the one cycle after the clock edge at which sig_in[i] is first sampled as 0, following a sample of 1.
- R9: In both-edges mode, evt_vec[i] is 1 for the one cycle after any clock edge at which the sample of sig_in[i] differs from the previous sample.
- R10: A detector whose mask bit is 1 never raises its event bit, whatever its mode and input.
- R11: evt_any is 1 in exactly those cycles in which at least one evt_vec bit is 1.
- R12: Synchronous reset sets all modes to rising, all masks to 0, the selector to 0, and evt_vec and evt_any to 0. The first clock edge after reset produces no events, whatever value the input has.
- R13: rd_data shows the word for the rd_addr that was sampled at the previous clock edge. Addresses not listed in R1, R5 and R6 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 6 | Write address (0x00 selector, 0x01 mode, 0x02 mask) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Registered read data |
| sig_in | input | 256 | Monitored input bus, one bit per detector |
| evt_vec | output | 256 | Per-bit event flags, one cycle wide |
| evt_any | output | 1 | High when any event flag is high |

## Verification
The assertions assume that sig_in is a plain synchronous bus that is known at every sampled edge. They also assume that the configuration port changes only between edges, and that a mode or mask write is preceded by a selector write whenever it is meant for a different detector. The stimulus drives every input on the falling clock edge. It programs all 256 detectors through the selector-then-value sequence, with invalid mode and mask values mixed in. It then applies whole-bus patterns (constant levels, full swings, alternating bits and pseudo-random vectors) while the configuration stays fixed, so that each expected event vector follows from the last two applied vectors and the model of the configuration.

// File: rtl/edgebank_pkg.sv
package edgebank_pkg;

  // Register-port address map (shared by the write decoder and the read mux)
  localparam int ADR_SELECT    = 'h00;
  localparam int ADR_MODE      = 'h01;
  localparam int ADR_MASK      = 'h02;
  localparam int ADR_CTRL_BASE = 'h10;
  localparam int ADR_MASK_BASE = 'h20;

  typedef enum logic [1:0] {
    EM_RISE = 2'd0,
    EM_FALL = 2'd1,
    EM_BOTH = 2'd2
  } edge_mode_e;

endpackage

// File: rtl/edgebank_cfg.sv
module edgebank_cfg
  import edgebank_pkg::*;
#(
  parameter int N_DET  = 256,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int IDX_W = (N_DET > 1) ? $clog2(N_DET) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [IDX_W-1:0]     sel_idx,
  output logic [2*N_DET-1:0]   mode_vec,
  output logic [N_DET-1:0]     mask_vec
);

  logic [IDX_W-1:0]   sel_q;
  logic [2*N_DET-1:0] mode_q;
  logic [N_DET-1:0]   mask_q;

  logic hit_sel, hit_mode, hit_mask;
  logic mode_ok, mask_ok;

  assign hit_sel  = wr_en && (wr_addr == ADDR_W'(ADR_SELECT));
  assign hit_mode = wr_en && (wr_addr == ADDR_W'(ADR_MODE));
  assign hit_mask = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
  assign mode_ok  = (wr_data <= DATA_W'(EM_BOTH));
  assign mask_ok  = (wr_data <= DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      mode_q <= '0;
      mask_q <= '0;
    end else begin
      if (hit_sel)
        sel_q <= wr_data[IDX_W-1:0];
      if (hit_mode && mode_ok)
        mode_q[{sel_q, 1'b0} +: 2] <= wr_data[1:0];
      if (hit_mask && mask_ok)
        mask_q[sel_q] <= wr_data[0];
    end
  end

  assign sel_idx  = sel_q;
  assign mode_vec = mode_q;
  assign mask_vec = mask_q;

  AST_BAD_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hit_mode && (wr_data > DATA_W'(2))) |=> $stable(mode_q)); // R3

  AST_BAD_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hit_mask && (wr_data > DATA_W'(1))) |=> $stable(mask_q)); // R4

  AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (hit_mask && (wr_data <= DATA_W'(1)) && !hit_sel) |=>
      $countones(mask_q ^ $past(mask_q)) <= 1); // R4

endmodule

// File: rtl/edgebank_detect.sv
module edgebank_detect
  import edgebank_pkg::*;
#(
  parameter int N_DET = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_DET-1:0]   sig_in,
  input  logic [2*N_DET-1:0] mode_vec,
  input  logic [N_DET-1:0]   mask_vec,
  output logic [N_DET-1:0]   evt_vec,
  output logic               evt_any
);

  logic [N_DET-1:0] prev_q;
  logic             warm_q;
  logic [N_DET-1:0] evt_nxt;
  logic [N_DET-1:0] evt_q;
  logic             any_q;

  for (genvar g = 0; g < N_DET; g++) begin : g_det
    logic rise_w, fall_w, match_w;
    assign rise_w = sig_in[g] & ~prev_q[g];
    assign fall_w = ~sig_in[g] & prev_q[g];
    always_comb begin
      case (edge_mode_e'(mode_vec[2*g +: 2]))
        EM_RISE: match_w = rise_w;
        EM_FALL: match_w = fall_w;
        EM_BOTH: match_w = rise_w | fall_w;
        default: match_w = 1'b0;
      endcase
    end
    assign evt_nxt[g] = warm_q & ~mask_vec[g] & match_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      warm_q <= 1'b0;
      evt_q  <= '0;
      any_q  <= 1'b0;
    end else begin
      prev_q <= sig_in;
      warm_q <= 1'b1;
      evt_q  <= evt_nxt;
      any_q  <= |evt_nxt;
    end
  end

  assign evt_vec = evt_q;
  assign evt_any = any_q;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (evt_q & $past(mask_vec)) == '0); // R10

  AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !warm_q |=> (evt_q == '0)); // R12

  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (evt_q & ~($past(sig_in) ^ $past(prev_q))) == '0); // R9

endmodule

// File: rtl/edgebank_readback.sv
module edgebank_readback
  import edgebank_pkg::*;
#(
  parameter int N_DET  = 256,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int IDX_W   = (N_DET > 1) ? $clog2(N_DET) : 1,
  localparam int N_CWORD = (2 * N_DET) / DATA_W,
  localparam int N_MWORD = N_DET / DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [IDX_W-1:0]   sel_idx,
  input  logic [2*N_DET-1:0] mode_vec,
  input  logic [N_DET-1:0]   mask_vec,
  output logic [DATA_W-1:0]  rd_data
);

  logic [DATA_W-1:0] cword [N_CWORD];
  logic [DATA_W-1:0] mword [N_MWORD];
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rd_q;

  for (genvar w = 0; w < N_CWORD; w++) begin : g_cw
    assign cword[w] = mode_vec[w*DATA_W +: DATA_W];
  end
  for (genvar w = 0; w < N_MWORD; w++) begin : g_mw
    assign mword[w] = mask_vec[w*DATA_W +: DATA_W];
  end

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == ADDR_W'(ADR_SELECT))
      rd_nxt = {{(DATA_W-IDX_W){1'b0}}, sel_idx};
    for (int w = 0; w < N_CWORD; w++)
      if (rd_addr == ADDR_W'(ADR_CTRL_BASE + w)) rd_nxt = cword[w];
    for (int w = 0; w < N_MWORD; w++)
      if (rd_addr == ADDR_W'(ADR_MASK_BASE + w)) rd_nxt = mword[w];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= ADDR_W'(ADR_MASK_BASE + N_MWORD)) |=> (rd_q == '0)); // R13

endmodule

// File: rtl/pin_edge_monitor.sv
module pin_edge_monitor #(
  parameter int N_DET  = 256,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [N_DET-1:0]   sig_in,
  output logic [N_DET-1:0]   evt_vec,
  output logic               evt_any
);

  localparam int IDX_W = (N_DET > 1) ? $clog2(N_DET) : 1;

  logic [IDX_W-1:0]   sel_idx;
  logic [2*N_DET-1:0] mode_vec;
  logic [N_DET-1:0]   mask_vec;

  edgebank_cfg #(.N_DET(N_DET), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sel_idx  (sel_idx),
    .mode_vec (mode_vec),
    .mask_vec (mask_vec)
  );

  edgebank_detect #(.N_DET(N_DET)) u_det (
    .clk      (clk),
    .rst      (rst),
    .sig_in   (sig_in),
    .mode_vec (mode_vec),
    .mask_vec (mask_vec),
    .evt_vec  (evt_vec),
    .evt_any  (evt_any)
  );

  edgebank_readback #(.N_DET(N_DET), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (rd_addr),
    .sel_idx  (sel_idx),
    .mode_vec (mode_vec),
    .mask_vec (mask_vec),
    .rd_data  (rd_data)
  );

  AST_ANY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    evt_any == (|evt_vec)); // R11

endmodule

// File: tb/test_pin_edge_monitor.sv
`timescale 1ns/1ps
module test_pin_edge_monitor;

  localparam int N = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [5:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  sig_in = '0;
  logic [N-1:0]  evt_vec;
  logic          evt_any;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int       mode_m [N];
  bit       mask_m [N];
  logic [N-1:0] prev_v;

  always #4 clk = ~clk;

  pin_edge_monitor i_pin_edge_monitor (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sig_in(sig_in),
    .evt_vec(evt_vec), .evt_any(evt_any)
  );

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkvec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    rd_addr = 6'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [N-1:0] expect_evt(logic [N-1:0] v, logic [N-1:0] p);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      logic r, f;
      r = v[i] & ~p[i];
      f = ~v[i] & p[i];
      case (mode_m[i])
        0: e[i] = r;
        1: e[i] = f;
        default: e[i] = r | f;
      endcase
      if (mask_m[i]) e[i] = 1'b0;
    end
    return e;
  endfunction

  // drive a vector, let one edge pass, check the registered events
  task automatic step(logic [N-1:0] v, string req);
    logic [N-1:0] e;
    sig_in = v;
    @(negedge clk);
    e = expect_evt(v, prev_v);
    chkvec(req, evt_vec, e);
    chk32("R11 evt_any", 32'(evt_any), 32'(|e));
    prev_v = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    logic [N-1:0] pat;

    for (int i = 0; i < N; i++) begin mode_m[i] = 0; mask_m[i] = 0; end

    // R12: outputs while reset is held
    repeat (4) @(negedge clk);
    chkvec("R12 evt during reset", evt_vec, '0);
    chk32("R12 any during reset", 32'(evt_any), 0);

    // R12: first edge after reset is quiet even with every bit risen
    sig_in = '1;
    rst = 1'b0;
    @(negedge clk);
    chkvec("R12 first sample quiet", evt_vec, '0);
    chk32("R12 first sample any", 32'(evt_any), 0);
    prev_v = '1;

    // R12: configuration reset values
    rd(0, v); chk32("R12 selector reset", v, 0);
    for (int w = 0; w < 16; w++) begin rd(16 + w, v); chk32("R12 control reset", v, 0); end
    for (int w = 0; w < 8; w++)  begin rd(32 + w, v); chk32("R12 mask reset", v, 0); end

    // R13: unmapped addresses
    rd(3, v);  chk32("R13 unmapped 0x03", v, 0);
    rd(40, v); chk32("R13 unmapped 0x28", v, 0);
    rd(63, v); chk32("R13 unmapped 0x3f", v, 0);

    // R2 R3 R4: program every detector, with invalid writes mixed in
    for (int i = 0; i < N; i++) begin
      int m;
      wr(0, i);
      m = (i + i / 16) % 3;
      wr(1, m); mode_m[i] = m;
      if (i % 5 == 0) wr(1, 3 + (i % 29));
      wr(2, (i % 7 == 3) ? 1 : 0); mask_m[i] = (i % 7 == 3);
      if (i % 11 == 0) wr(2, 2 + i);
    end

    // R1: selector readback
    rd(0, v); chk32("R1 selector after sweep", v, 255);
    wr(0, 37);
    rd(0, v); chk32("R1 selector 37", v, 37);

    // R5 R2 R3: packed control words
    for (int w = 0; w < 16; w++) begin
      e = '0;
      for (int j = 0; j < 16; j++) e[2*j +: 2] = 2'(mode_m[16*w + j]);
      rd(16 + w, v); chk32("R5 control word", v, e);
    end
    // R6 R4: packed mask words
    for (int w = 0; w < 8; w++) begin
      e = '0;
      for (int j = 0; j < 32; j++) e[j] = mask_m[32*w + j];
      rd(32 + w, v); chk32("R6 mask word", v, e);
    end

    // R7 R8 R9 R10: whole-bus patterns
    step('1, "R7 hold high");
    step('0, "R8 full fall");
    step('1, "R7 full rise");
    step('1, "R9 no change");
    step('0, "R8 full fall again");
    pat = '0;
    for (int k = 0; k < N / 2; k++) pat[2*k] = 1'b1;
    step(pat, "R7 even bits rise");
    step(~pat, "R9 all bits swap");
    step(pat, "R9 all bits swap back");
    for (int n = 0; n < 40; n++) begin
      logic [N-1:0] r;
      for (int k = 0; k < N / 32; k++) r[32*k +: 32] = $urandom;
      step(r, "R9 random vector");
    end

    // R10: mask a detector that is about to see its edge
    wr(0, 8); wr(2, 1); mask_m[8] = 1;
    wr(1, 2); mode_m[8] = 2;
    step(prev_v ^ (N'(1) << 8), "R10 masked toggle silent");
    wr(2, 0); mask_m[8] = 0;
    step(prev_v ^ (N'(1) << 8), "R9 unmasked toggle fires");
    step(prev_v, "R7 quiet after pulse");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule